// File: doc/BRIEF.md
# Word Load/Store Address Generator

This block is one issue stage in front of the data memory port of a 64-bit fixed-point core. It handles the word-sized loads and stores. It takes a 32-bit instruction word together with the values already read from the register file for the base, index and source register fields. In the next cycle it presents the effective address, a load or store strobe, the extension mode for the returned word, the low 32 bits of store data, and the write-enables for the destination register and for base-register writeback.

A small state machine sequences the stage. It has two states: `ST_IDLE` (nothing presented) and `ST_ISSUE` (one decoded operation presented). The transitions are:
- `IDLE->ISSUE` and `ISSUE->ISSUE` when `in_valid` is high at a clock edge.
- `ISSUE->IDLE` and `IDLE->IDLE` when `in_valid` is low.

Each accepted word is captured into a payload register. All outputs are driven from the current state and that payload.

Instruction field positions use bit 0 as the least significant bit:

| Bits | Field |
|------|-------|
| [31:26] | primary opcode |
| [25:21] | destination/source register index |
| [20:16] | base register index |
| [15:0] | 16-bit displacement |
| [15:2] | 14-bit scaled displacement |
| [1:0] | sub-opcode of the scaled form |
| [10:1] | extended opcode of the indexed forms |

Invalid forms raise `illegal`, and unknown encodings raise `decode_miss`. Neither of them issues a memory access. Reservation tracking for the reserve/conditional pair happens elsewhere; this block only flags those operations on `resv_op`.

Top module: `lsw_wordgen`

## Requirements
- R1: During and after reset, until a word is accepted, `out_valid`, `mem_rd`, `mem_wr`, `dest_we`, `base_we`, `illegal` and `decode_miss` are all low.
- R2: Primary opcodes 32 (load, zero-extend), 33 (load, zero-extend, update), 36 (store) and 37 (store, update) form the address as base plus the sign-extended bits [15:0], wrapping modulo 2^64.
- R3: Primary opcode 58 with bits [1:0] equal to 2 is a sign-extending load whose address is base plus the sign-extended bits [15:2] shifted left by two. Other values of bits [1:0] under opcode 58 are a decode miss.
- R4: When the base field bits [20:16] are zero, the base term is zero and the base register value has no effect on the address.
- R5: Primary opcode 31 with extended opcode bits [10:1] in {23, 55, 341, 373, 151, 183, 20, 150} forms the address as base plus index value.
- R6: `sign_ext` is high for loads with opcode 58/2 and for extended opcodes 341 and 373. It is low for the other loads. Every valid load raises `mem_rd` and `dest_we`, with `dest_idx` equal to bits [25:21].
- R7: Every valid store raises `mem_wr`, drives `wr_data` with the low 32 bits of `src_val`, and keeps `dest_we` and `sign_ext` low.
- R8: Opcodes 33 and 37 and extended opcodes 55, 373 and 183 are update forms. They raise `base_we`, with `base_idx` equal to bits [20:16], in the same cycle as the strobe.
- R9: An update form with a base field of zero, or an update load whose base field equals bits [25:21], raises `illegal`. It produces no strobe, no `dest_we` and no `base_we`.
- R10: Any other encoding raises `decode_miss` and produces no strobe and no register write. At most one of `mem_rd`, `mem_wr`, `illegal` and `decode_miss` is high at any time.
- R11: The address sum wraps modulo 2^64.
- R12: Extended opcode 20 is a zero-extending indexed load and extended opcode 150 is an indexed store. Both raise `resv_op`, and no other operation does.
- R13: A word accepted at a rising edge with `in_valid` high is presented from that edge to the next one. If `in_valid` is low at an edge, `out_valid` is low afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| base_val | input | 64 | Value of the register named by bits [20:16] |
| index_val | input | 64 | Value of the register named by bits [15:11] |
| src_val | input | 64 | Value of the register named by bits [25:21] |
| out_valid | output | 1 | A decoded operation is presented |
| mem_rd | output | 1 | Load strobe |
| mem_wr | output | 1 | Store strobe |
| sign_ext | output | 1 | Loaded word is sign-extended (else zero-extended) |
| resv_op | output | 1 | Operation is the reserve load or the conditional store |
| illegal | output | 1 | Invalid update form |
| decode_miss | output | 1 | Encoding not handled by this block |
| dest_we | output | 1 | Write loaded word to destination register |
| base_we | output | 1 | Write effective address back to base register |
| eff_addr | output | 64 | Effective address (zero when no strobe) |
| wr_data | output | 32 | Store data (zero when no store) |
| dest_idx | output | 5 | Destination register index |
| base_idx | output | 5 | Base register index for writeback |

## Verification
A corrupted state register or payload shows up on the ports in the very next cycle. Depending on which bit is wrong, it appears as a strobe without a preceding `in_valid`, a presented operation that never clears, or a wrong address, extension flag or write-enable. The bench runs a behavioural model alongside the design and compares the whole output set every cycle. Because of that, any single wrong decode, wrong offset selection or missing zero-base substitution fails at the first cycle that presents the affected operation. Directed words cover every opcode, the zero base field, both invalid-form rules, wrapping and idle cycles. A randomized run then mixes the legal encodings with fields that hit the corner cases by chance.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    localparam int OPC_W = 6;
    localparam int XOP_W = 10;

    localparam logic [OPC_W-1:0] OPC_LDZ     = 6'd32;
    localparam logic [OPC_W-1:0] OPC_LDZ_UPD = 6'd33;
    localparam logic [OPC_W-1:0] OPC_ST      = 6'd36;
    localparam logic [OPC_W-1:0] OPC_ST_UPD  = 6'd37;
    localparam logic [OPC_W-1:0] OPC_SCALED  = 6'd58;
    localparam logic [OPC_W-1:0] OPC_INDEXED = 6'd31;

    localparam logic [1:0] SUB_LDS = 2'd2;

    localparam logic [XOP_W-1:0] XOP_LDZ     = 10'd23;
    localparam logic [XOP_W-1:0] XOP_LDZ_UPD = 10'd55;
    localparam logic [XOP_W-1:0] XOP_LDS     = 10'd341;
    localparam logic [XOP_W-1:0] XOP_LDS_UPD = 10'd373;
    localparam logic [XOP_W-1:0] XOP_ST      = 10'd151;
    localparam logic [XOP_W-1:0] XOP_ST_UPD  = 10'd183;
    localparam logic [XOP_W-1:0] XOP_LD_RESV = 10'd20;
    localparam logic [XOP_W-1:0] XOP_ST_COND = 10'd150;

    typedef enum logic [1:0] {
        XFER_NONE  = 2'd0,
        XFER_LOAD  = 2'd1,
        XFER_STORE = 2'd2
    } xfer_e;

    typedef enum logic [1:0] {
        OFS_D16   = 2'd0,
        OFS_DS14  = 2'd1,
        OFS_INDEX = 2'd2
    } ofs_e;

    typedef struct packed {
        xfer_e xfer;
        ofs_e  ofs;
        logic  sext;
        logic  upd;
        logic  resv;
    } dec_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } stage_e;

endpackage

// File: rtl/lsw_decode.sv
module lsw_decode
    import lsw_pkg::*;
#(
    parameter int ILEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic [ILEN-1:0] instr,
    output dec_t            dec,
    output logic            bad_form
);
    localparam int OPC_LSB = ILEN - OPC_W;
    localparam int RT_LSB  = OPC_LSB - REG_AW;
    localparam int RA_LSB  = RT_LSB - REG_AW;

    logic [OPC_W-1:0]  opc;
    logic [XOP_W-1:0]  xop;
    logic [1:0]        sub;
    logic [REG_AW-1:0] rt_f;
    logic [REG_AW-1:0] ra_f;

    assign opc  = instr[ILEN-1:OPC_LSB];
    assign rt_f = instr[OPC_LSB-1:RT_LSB];
    assign ra_f = instr[RT_LSB-1:RA_LSB];
    assign xop  = instr[XOP_W:1];
    assign sub  = instr[1:0];

    always_comb begin
        dec = '{xfer: XFER_NONE, ofs: OFS_D16, sext: 1'b0, upd: 1'b0, resv: 1'b0};
        unique case (opc)
            OPC_LDZ:     dec.xfer = XFER_LOAD;
            OPC_LDZ_UPD: begin dec.xfer = XFER_LOAD;  dec.upd = 1'b1; end
            OPC_ST:      dec.xfer = XFER_STORE;
            OPC_ST_UPD:  begin dec.xfer = XFER_STORE; dec.upd = 1'b1; end
            OPC_SCALED: begin
                if (sub == SUB_LDS) begin
                    dec.xfer = XFER_LOAD;
                    dec.ofs  = OFS_DS14;
                    dec.sext = 1'b1;
                end
            end
            OPC_INDEXED: begin
                dec.ofs = OFS_INDEX;
                unique case (xop)
                    XOP_LDZ:     dec.xfer = XFER_LOAD;
                    XOP_LDZ_UPD: begin dec.xfer = XFER_LOAD; dec.upd = 1'b1; end
                    XOP_LDS:     begin dec.xfer = XFER_LOAD; dec.sext = 1'b1; end
                    XOP_LDS_UPD: begin dec.xfer = XFER_LOAD; dec.sext = 1'b1; dec.upd = 1'b1; end
                    XOP_ST:      dec.xfer = XFER_STORE;
                    XOP_ST_UPD:  begin dec.xfer = XFER_STORE; dec.upd = 1'b1; end
                    XOP_LD_RESV: begin dec.xfer = XFER_LOAD; dec.resv = 1'b1; end
                    XOP_ST_COND: begin dec.xfer = XFER_STORE; dec.resv = 1'b1; end
                    default:     dec.xfer = XFER_NONE;
                endcase
            end
            default: dec.xfer = XFER_NONE;
        endcase
    end

    // Update with a zero base field, or an update load onto its own base.
    always_comb begin
        bad_form = 1'b0;
        if (dec.upd) begin
            if (ra_f == '0)
                bad_form = 1'b1;
            else if (dec.xfer == XFER_LOAD && ra_f == rt_f)
                bad_form = 1'b1;
        end
    end

endmodule

// File: rtl/lsw_agen.sv
module lsw_agen
    import lsw_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int REG_AW = 5,
    parameter int DISP_W = 16
) (
    input  logic [REG_AW-1:0] ra_f,
    input  ofs_e              ofs_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   index_val,
    output logic [XLEN-1:0]   ea
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] base_term;
    logic [XLEN-1:0] ofs_term;

    // A zero base field names the constant zero, not register 0.
    assign base_term = (ra_f == '0) ? '0 : base_val;

    always_comb begin
        unique case (ofs_sel)
            OFS_D16:   ofs_term = {{EXT_W{disp[DISP_W-1]}}, disp};
            OFS_DS14:  ofs_term = {{EXT_W{disp[DISP_W-1]}}, disp[DISP_W-1:2], 2'b00};
            OFS_INDEX: ofs_term = index_val;
            default:   ofs_term = '0;
        endcase
    end

    assign ea = base_term + ofs_term;

endmodule

// File: rtl/lsw_wordgen.sv
module lsw_wordgen
    import lsw_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int ILEN   = 32,
    parameter int REG_AW = 5,
    parameter int MEM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ILEN-1:0]   instr,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   index_val,
    input  logic [XLEN-1:0]   src_val,
    output logic              out_valid,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              sign_ext,
    output logic              resv_op,
    output logic              illegal,
    output logic              decode_miss,
    output logic              dest_we,
    output logic              base_we,
    output logic [XLEN-1:0]   eff_addr,
    output logic [MEM_W-1:0]  wr_data,
    output logic [REG_AW-1:0] dest_idx,
    output logic [REG_AW-1:0] base_idx
);
    localparam int DISP_W = 16;
    localparam int RT_LSB = ILEN - OPC_W - REG_AW;
    localparam int RA_LSB = RT_LSB - REG_AW;

    typedef struct packed {
        dec_t              dec;
        logic              bad;
        logic [XLEN-1:0]   ea;
        logic [MEM_W-1:0]  wdata;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] ra;
    } payload_t;

    stage_e   state, state_nx;
    payload_t pl;
    dec_t     dec_w;
    logic     bad_w;
    logic [XLEN-1:0]   ea_w;
    logic [REG_AW-1:0] rt_w;
    logic [REG_AW-1:0] ra_w;
    logic     known, go;
    logic     unused_src_hi;

    assign rt_w = instr[RT_LSB+REG_AW-1:RT_LSB];
    assign ra_w = instr[RA_LSB+REG_AW-1:RA_LSB];
    assign unused_src_hi = ^src_val[XLEN-1:MEM_W];

    lsw_decode #(.ILEN(ILEN), .REG_AW(REG_AW)) i_decode (
        .instr    (instr),
        .dec      (dec_w),
        .bad_form (bad_w)
    );

    lsw_agen #(.XLEN(XLEN), .REG_AW(REG_AW), .DISP_W(DISP_W)) i_agen (
        .ra_f      (ra_w),
        .ofs_sel   (dec_w.ofs),
        .disp      (instr[DISP_W-1:0]),
        .base_val  (base_val),
        .index_val (index_val),
        .ea        (ea_w)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (in_valid)  state_nx = ST_ISSUE;
            ST_ISSUE: if (!in_valid) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Payload captured with each accepted word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pl <= '0;
        end else if (in_valid) begin
            pl.dec   <= dec_w;
            pl.bad   <= bad_w;
            pl.ea    <= ea_w;
            pl.wdata <= (dec_w.xfer == XFER_STORE) ? src_val[MEM_W-1:0] : '0;
            pl.rt    <= rt_w;
            pl.ra    <= ra_w;
        end
    end

    // Outputs
    always_comb begin
        out_valid   = 1'b0;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        sign_ext    = 1'b0;
        resv_op     = 1'b0;
        illegal     = 1'b0;
        decode_miss = 1'b0;
        dest_we     = 1'b0;
        base_we     = 1'b0;
        eff_addr    = '0;
        wr_data     = '0;
        dest_idx    = '0;
        base_idx    = '0;
        known       = 1'b0;
        go          = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ISSUE: begin
                out_valid   = 1'b1;
                known       = (pl.dec.xfer != XFER_NONE);
                decode_miss = !known;
                illegal     = known && pl.bad;
                go          = known && !pl.bad;
                mem_rd      = go && (pl.dec.xfer == XFER_LOAD);
                mem_wr      = go && (pl.dec.xfer == XFER_STORE);
                sign_ext    = mem_rd && pl.dec.sext;
                resv_op     = go && pl.dec.resv;
                dest_we     = mem_rd;
                base_we     = go && pl.dec.upd;
                eff_addr    = go ? pl.ea : '0;
                wr_data     = mem_wr ? pl.wdata : '0;
                dest_idx    = mem_rd ? pl.rt : '0;
                base_idx    = base_we ? pl.ra : '0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lsw_wordgen_chk.sv
module lsw_wordgen_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              sign_ext,
    input logic              illegal,
    input logic              decode_miss,
    input logic              dest_we,
    input logic              base_we,
    input logic [REG_AW-1:0] base_idx
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(mem_rd || mem_wr || illegal || decode_miss || dest_we || base_we));

    assert_load_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> dest_we);

    assert_store_no_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (!dest_we && !sign_ext));

    assert_update_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |-> ((mem_rd || mem_wr) && base_idx != '0));

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(mem_rd || mem_wr || dest_we || base_we));

    assert_outcome_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, illegal, decode_miss}));

    assert_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

bind lsw_wordgen lsw_wordgen_chk #(.REG_AW(REG_AW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .sign_ext    (sign_ext),
    .illegal     (illegal),
    .decode_miss (decode_miss),
    .dest_we     (dest_we),
    .base_we     (base_we),
    .base_idx    (base_idx)
);

// File: tb/test_lsw_wordgen.sv
module test_lsw_wordgen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] base_val = '0, index_val = '0, src_val = '0;
    logic        out_valid, mem_rd, mem_wr, sign_ext, resv_op, illegal, decode_miss, dest_we, base_we;
    logic [63:0] eff_addr;
    logic [31:0] wr_data;
    logic [4:0]  dest_idx, base_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected outputs
    logic        e_valid, e_rd, e_wr, e_sx, e_resv, e_ill, e_miss, e_dwe, e_bwe;
    logic [63:0] e_ea;
    logic [31:0] e_wd;
    logic [4:0]  e_didx, e_bidx;

    always #2 clk = ~clk;

    lsw_wordgen i_lsw_wordgen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .base_val(base_val), .index_val(index_val), .src_val(src_val),
        .out_valid(out_valid), .mem_rd(mem_rd), .mem_wr(mem_wr), .sign_ext(sign_ext),
        .resv_op(resv_op), .illegal(illegal), .decode_miss(decode_miss),
        .dest_we(dest_we), .base_we(base_we), .eff_addr(eff_addr), .wr_data(wr_data),
        .dest_idx(dest_idx), .base_idx(base_idx)
    );

    function automatic logic [31:0] dform(int op, int rt, int ra, logic [15:0] d);
        return {op[5:0], rt[4:0], ra[4:0], d};
    endfunction

    function automatic logic [31:0] dsform(int rt, int ra, logic [13:0] ds, logic [1:0] sub);
        return {6'd58, rt[4:0], ra[4:0], ds, sub};
    endfunction

    function automatic logic [31:0] xform(int rt, int ra, int rb, int xo);
        return {6'd31, rt[4:0], ra[4:0], rb[4:0], xo[9:0], 1'b0};
    endfunction

    // Behavioural reference: expected outputs one cycle after acceptance.
    task automatic model(input logic v, input logic [31:0] w, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] s);
        int op, rt, ra, xo, kind;
        logic sx, upd, rsv;
        logic [63:0] off, basev;
        e_valid = 0; e_rd = 0; e_wr = 0; e_sx = 0; e_resv = 0; e_ill = 0; e_miss = 0;
        e_dwe = 0; e_bwe = 0; e_ea = '0; e_wd = '0; e_didx = '0; e_bidx = '0;
        if (!v) return;
        e_valid = 1;
        op = int'(w[31:26]); rt = int'(w[25:21]); ra = int'(w[20:16]); xo = int'(w[10:1]);
        kind = 0; sx = 0; upd = 0; rsv = 0;
        off = 64'(signed'(w[15:0]));
        case (op)
            32: kind = 1;
            33: begin kind = 1; upd = 1; end
            36: kind = 2;
            37: begin kind = 2; upd = 1; end
            58: if (w[1:0] == 2'd2) begin
                    kind = 1; sx = 1;
                    off = 64'(signed'({w[15:2], 2'b00}));
                end
            31: begin
                off = b;
                case (xo)
                    23:  kind = 1;
                    55:  begin kind = 1; upd = 1; end
                    341: begin kind = 1; sx = 1; end
                    373: begin kind = 1; sx = 1; upd = 1; end
                    151: kind = 2;
                    183: begin kind = 2; upd = 1; end
                    20:  begin kind = 1; rsv = 1; end
                    150: begin kind = 2; rsv = 1; end
                    default: kind = 0;
                endcase
            end
            default: kind = 0;
        endcase
        basev = (ra == 0) ? 64'd0 : a;
        if (kind == 0) begin
            e_miss = 1;
        end else if (upd && (ra == 0 || (kind == 1 && ra == rt))) begin
            e_ill = 1;
        end else begin
            e_ea = basev + off;
            e_resv = rsv;
            e_bwe = upd;
            e_bidx = upd ? ra[4:0] : 5'd0;
            if (kind == 1) begin
                e_rd = 1; e_dwe = 1; e_sx = sx; e_didx = rt[4:0];
            end else begin
                e_wr = 1; e_wd = s[31:0];
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [172:0] act, exp;
        act = {out_valid, mem_rd, mem_wr, sign_ext, resv_op, illegal, decode_miss,
               dest_we, base_we, eff_addr, wr_data, dest_idx, base_idx};
        exp = {e_valid, e_rd, e_wr, e_sx, e_resv, e_ill, e_miss,
               e_dwe, e_bwe, e_ea, e_wd, e_didx, e_bidx};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input string tag, input logic v, input logic [31:0] w,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] s);
        in_valid = v; instr = w; base_val = a; index_val = b; src_val = s;
        model(v, w, a, b, s);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        @(negedge clk);
        model(1'b0, '0, '0, '0, '0);
        compare("R1 in reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        issue("R2 load zx D16", 1, dform(32, 3, 4, 16'h0010), 64'h1000, 0, 0);
        issue("R2 load neg disp", 1, dform(32, 3, 4, 16'hFFF0), 64'h1000, 0, 0);
        issue("R2 R7 store", 1, dform(36, 5, 6, 16'h0008), 64'h2000, 0, 64'hDEADBEEF_12345678);
        issue("R2 R8 load update", 1, dform(33, 7, 8, 16'h0004), 64'h3000, 0, 0);
        issue("R2 R8 store update", 1, dform(37, 8, 8, 16'h8000), 64'h3000, 0, 64'h55);
        issue("R3 scaled neg", 1, dsform(9, 10, 14'h3FFF, 2'd2), 64'h100, 0, 0);
        issue("R3 scaled pos", 1, dsform(9, 10, 14'h0003, 2'd2), 64'h100, 0, 0);
        issue("R3 R10 scaled sub0 miss", 1, dsform(9, 10, 14'h0003, 2'd0), 64'h100, 0, 0);
        issue("R4 zero base D16", 1, dform(32, 2, 0, 16'h0040), 64'hFFFF_0000_1111_2222, 0, 0);
        issue("R4 zero base indexed", 1, xform(2, 0, 3, 23), 64'hABCD, 64'h700, 0);
        issue("R5 indexed zx", 1, xform(2, 4, 5, 23), 64'h1000, 64'h24, 0);
        issue("R5 R6 indexed sx", 1, xform(2, 4, 5, 341), 64'h1000, 64'hFFFF_FFFF_FFFF_FFFC, 0);
        issue("R5 R8 indexed sx update", 1, xform(2, 4, 5, 373), 64'h1000, 64'h8, 0);
        issue("R5 R8 indexed zx update", 1, xform(2, 4, 5, 55), 64'h1000, 64'h8, 0);
        issue("R5 R7 indexed store", 1, xform(6, 4, 5, 151), 64'h1000, 64'h10, 64'h1_0000_00FF);
        issue("R5 R8 indexed store update", 1, xform(6, 4, 5, 183), 64'h1000, 64'h10, 64'h77);
        issue("R9 store update zero base", 1, dform(37, 3, 0, 16'h0004), 64'h10, 0, 0);
        issue("R9 load update base eq dest", 1, dform(33, 6, 6, 16'h0004), 64'h10, 0, 0);
        issue("R9 indexed load update zero base", 1, xform(3, 0, 4, 55), 0, 64'h10, 0);
        issue("R10 unknown primary", 1, dform(14, 1, 2, 16'h0001), 64'h10, 0, 0);
        issue("R10 unknown extended", 1, xform(1, 2, 3, 999), 64'h10, 64'h10, 0);
        issue("R11 wrap", 1, dform(32, 1, 2, 16'h0002), 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
        issue("R12 reserve load", 1, xform(4, 5, 6, 20), 64'h800, 64'h8, 0);
        issue("R12 conditional store", 1, xform(4, 5, 6, 150), 64'h800, 64'h8, 64'hCAFE);
        issue("R13 idle drops", 0, dform(32, 1, 2, 16'h0002), 64'h40, 0, 0);
        issue("R13 idle again", 0, '0, 0, 0, 0);
        issue("R13 restart", 1, dform(36, 1, 2, 16'h0002), 64'h40, 0, 64'h9);

        for (int i = 0; i < 400; i++) begin
            int pick, rt, ra;
            rt = $urandom_range(0, 3);
            ra = $urandom_range(0, 3);
            pick = $urandom_range(0, 17);
            case (pick)
                0:  w = dform(32, rt, ra, 16'($urandom));
                1:  w = dform(33, rt, ra, 16'($urandom));
                2:  w = dform(36, rt, ra, 16'($urandom));
                3:  w = dform(37, rt, ra, 16'($urandom));
                4:  w = dsform(rt, ra, 14'($urandom), 2'($urandom));
                5:  w = xform(rt, ra, 1, 23);
                6:  w = xform(rt, ra, 1, 55);
                7:  w = xform(rt, ra, 1, 341);
                8:  w = xform(rt, ra, 1, 373);
                9:  w = xform(rt, ra, 1, 151);
                10: w = xform(rt, ra, 1, 183);
                11: w = xform(rt, ra, 1, 20);
                12: w = xform(rt, ra, 1, 150);
                13: w = xform(rt, ra, 1, int'($urandom_range(0, 1023)));
                default: w = $urandom;
            endcase
            issue("random R2 R5 R9 R10", ($urandom_range(0, 7) != 0), w,
                  {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule